// File: doc/BRIEF.md
# HDLC Transmit Packet Length Tagger

This block sits on the write port of an HDLC transmit FIFO and marks packet boundaries for the transmitter that drains that FIFO. Software programs a packet length in bytes. Each byte that is accepted into the FIFO lowers a down-counter by one. The write that arrives while the counter holds one has a ninth bit set next to its data byte. That bit is the end-of-packet tag, and the serialiser downstream uses it to close the frame.

A cycle control input selects one of two behaviours after the tagged byte. When cycle is set, the counter reloads the programmed length, so a stream of equal-length packets needs no further programming. When cycle is clear, the counter rests at zero until software programs a new length. A programmed length of zero disables tagging. The current counter value is always visible on a status port.

Top module: `hdlc_tx_len_tagger`

## Requirements
- R1: After reset the count output is 0 and no write carries a tag, so tagging stays off until a length is programmed.
- R2: A pulse on `len_wr` loads `len_val` into the counter. The count output shows the new value on the cycle after the pulse. The load takes priority over any decrement requested in the same cycle.
- R3: A write is accepted when `wr_req` is high and `fifo_full` is low. Each accepted write lowers a nonzero count by one, and the new count appears on the cycle after the write.
- R4: An accepted write made while the count is 1 drives `fifo_wdata[8]` = 1. Every other write drives that bit to 0. `fifo_wdata[7:0]` always equals `wr_data`.
- R5: When `cycle_en` is 0, the count becomes 0 after the tagged write and no later write is tagged.
- R6: When `cycle_en` is 1, the count reloads the programmed length after the tagged write. Every L-th accepted write is then tagged.
- R7: When the programmed length is 0, no write is tagged and the count stays 0, whatever the value of `cycle_en`.
- R8: A write attempted while `fifo_full` is high gives `fifo_we` = 0 and no tag, and it leaves the count unchanged.
- R9: If a length is written in the same cycle as an accepted write, that write is tagged according to the count held before the load.
- R10: The count never exceeds the most recently programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_wr | input | 1 | Load strobe for the packet length |
| len_val | input | 8 | Packet length in bytes |
| cycle_en | input | 1 | Reload the length after each tagged byte |
| wr_req | input | 1 | Request to write one byte into the FIFO |
| wr_data | input | 8 | Byte to write |
| fifo_full | input | 1 | FIFO cannot accept a byte this cycle |
| fifo_we | output | 1 | Write strobe to the FIFO |
| fifo_wdata | output | 9 | Bit 8 is the end-of-packet tag, bits 7:0 are the data byte |
| count | output | 8 | Current counter value |

## Verification
Two cases are hard to reach from the ports. The first is a length load that lands in the same cycle as an accepted write, above all a load that coincides with the tagged write. The bench schedules these cases directly: it counts writes until the counter reaches 1, then pulses the load strobe together with a write. For lengths 0 to 10, in both modes, the bench also inserts periodic full-FIFO stalls. These stalls move the tagged byte away from the cycle where a naive cycle count would place it. The expected tags and counts come from modular arithmetic on the number of accepted writes.

// File: rtl/hdlc_tx_len_tagger_pkg.sv
package hdlc_tx_len_tagger_pkg;
    typedef enum logic [1:0] {
        NXT_HOLD   = 2'd0,
        NXT_DEC    = 2'd1,
        NXT_LOAD   = 2'd2,
        NXT_WRAP   = 2'd3
    } nxt_sel_e;
endpackage

// File: rtl/hdlc_tx_len_reg.sv
module hdlc_tx_len_reg #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    output logic [LEN_W-1:0] len_o
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (len_wr) begin
            st_d.len = len_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_o = st_q.len;

    assert_len_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        len_wr |=> (len_o == $past(len_val)));
endmodule

// File: rtl/hdlc_tx_len_count.sv
module hdlc_tx_len_count
    import hdlc_tx_len_tagger_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic [LEN_W-1:0] len,
    input  logic             cycle_en,
    output logic [LEN_W-1:0] count_o,
    output logic             last_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0] count;
    } st_t;

    st_t      st_d, st_q;
    nxt_sel_e sel;
    logic     at_one;

    assign at_one = (st_q.count == ONE);

    always_comb begin
        if (load) begin
            sel = NXT_LOAD;
        end else if (accept && at_one) begin
            sel = NXT_WRAP;
        end else if (accept && (st_q.count != '0)) begin
            sel = NXT_DEC;
        end else begin
            sel = NXT_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (sel)
            NXT_LOAD: st_d.count = load_val;
            NXT_WRAP: st_d.count = cycle_en ? len : '0;
            NXT_DEC:  st_d.count = st_q.count - ONE;
            default:  st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign last_o  = accept && at_one;

    assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !load && count_o > ONE) |=> (count_o == $past(count_o) - ONE));
    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !load && count_o == ONE && !cycle_en) |=> (count_o == '0));
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !load && count_o == ONE && cycle_en) |=> (count_o == len));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !load) |=> $stable(count_o));
endmodule

// File: rtl/hdlc_tx_len_pack.sv
module hdlc_tx_len_pack #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              wr_req,
    input  logic              fifo_full,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              last,
    output logic              accept,
    output logic              fifo_we,
    output logic [DATA_W:0]   fifo_wdata
);
    assign accept     = wr_req && !fifo_full;
    assign fifo_we    = accept;
    assign fifo_wdata = {last, wr_data};

    always_comb begin
        assert_full_blocks_R8: assert (!(fifo_full && fifo_we));
        assert_tag_with_we_R4: assert (!(fifo_wdata[DATA_W] && !fifo_we));
    end
endmodule

// File: rtl/hdlc_tx_len_tagger.sv
module hdlc_tx_len_tagger #(
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_wr,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              cycle_en,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fifo_full,
    output logic              fifo_we,
    output logic [DATA_W:0]   fifo_wdata,
    output logic [LEN_W-1:0]  count
);
    logic [LEN_W-1:0] len;
    logic             accept;
    logic             last;

    hdlc_tx_len_reg #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .len_wr  (len_wr),
        .len_val (len_val),
        .len_o   (len)
    );

    hdlc_tx_len_count #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .load     (len_wr),
        .load_val (len_val),
        .len      (len),
        .cycle_en (cycle_en),
        .count_o  (count),
        .last_o   (last)
    );

    hdlc_tx_len_pack #(.DATA_W(DATA_W)) u_pack (
        .wr_req     (wr_req),
        .fifo_full  (fifo_full),
        .wr_data    (wr_data),
        .last       (last),
        .accept     (accept),
        .fifo_we    (fifo_we),
        .fifo_wdata (fifo_wdata)
    );

    assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= len);
    assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (len == '0) |-> !fifo_wdata[DATA_W]);
endmodule

// File: tb/sim_hdlc_tx_len_tagger.sv
module sim_hdlc_tx_len_tagger;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       len_wr = 1'b0;
    logic [7:0] len_val = '0;
    logic       cycle_en = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_full = 1'b0;
    logic       fifo_we;
    logic [8:0] fifo_wdata;
    logic [7:0] count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hdlc_tx_len_tagger u0 (
        .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val),
        .cycle_en(cycle_en), .wr_req(wr_req), .wr_data(wr_data),
        .fifo_full(fifo_full), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .count(count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, check outputs 2 ns later, then let the
    // rising edge happen and return 2 ns after it.
    task automatic step(input bit lw, input int lv, input bit req, input int d, input bit full);
        @(negedge clk);
        len_wr = lw; len_val = 8'(lv); wr_req = req; wr_data = 8'(d); fifo_full = full;
        #2;
    endtask

    task automatic finish_edge();
        @(posedge clk);
        #2;
        len_wr = 1'b0; wr_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state
        chk(count == 0, "R1 count", count, 0);
        step(0, 0, 1, 8'h5A, 0);
        chk(fifo_wdata[8] == 0, "R1 no tag", fifo_wdata[8], 0);
        finish_edge();
        chk(count == 0, "R1 count hold", count, 0);

        // Sweep lengths and both modes with periodic full stalls
        for (int c = 0; c < 2; c++) begin
            for (int L = 0; L <= 10; L++) begin
                int k;
                cycle_en = c[0];
                step(1, L, 0, 0, 0);
                finish_edge();
                chk(count == L, "R2 load", count, L);
                k = 0;
                for (int i = 0; i < 2 * L + 4; i++) begin
                    bit full;
                    bit acc;
                    bit exp_tag;
                    int d;
                    int ec;
                    full = ((i % 4) == 3);
                    d = (i * 37 + L) % 256;
                    acc = !full;
                    if (L == 0) exp_tag = 0;
                    else if (c == 1) exp_tag = acc && (((k + 1) % L) == 0);
                    else exp_tag = acc && ((k + 1) == L);
                    step(0, 0, 1, d, full);
                    chk(fifo_we == acc, "R8 we", fifo_we, acc);
                    chk(fifo_wdata[7:0] == d[7:0], "R4 data", fifo_wdata[7:0], d);
                    if (L == 0) chk(fifo_wdata[8] == exp_tag, "R7 tag", fifo_wdata[8], exp_tag);
                    else if (c == 1) chk(fifo_wdata[8] == exp_tag, "R6 tag", fifo_wdata[8], exp_tag);
                    else chk(fifo_wdata[8] == exp_tag, "R4 R5 tag", fifo_wdata[8], exp_tag);
                    finish_edge();
                    if (acc) k++;
                    if (L == 0) ec = 0;
                    else if (c == 1) ec = ((k % L) == 0) ? L : L - (k % L);
                    else ec = (k >= L) ? 0 : L - k;
                    if (full) chk(count == ec, "R8 count hold", count, ec);
                    else chk(count == ec, "R3 count", count, ec);
                    chk(count <= L, "R10 bound", count, L);
                end
            end
        end

        // R9: load coinciding with a non-tagged write
        cycle_en = 1'b0;
        step(1, 5, 0, 0, 0); finish_edge();
        step(0, 0, 1, 1, 0); finish_edge();
        step(0, 0, 1, 2, 0); finish_edge();
        chk(count == 3, "R3 count", count, 3);
        step(1, 3, 1, 3, 0);
        chk(fifo_wdata[8] == 0, "R9 tag old count", fifo_wdata[8], 0);
        finish_edge();
        chk(count == 3, "R2 load wins", count, 3);
        step(0, 0, 1, 4, 0); finish_edge();
        step(0, 0, 1, 5, 0); finish_edge();
        chk(count == 1, "R3 count", count, 1);
        // R9: load coinciding with the tagged write
        step(1, 7, 1, 6, 0);
        chk(fifo_wdata[8] == 1, "R9 tag on load", fifo_wdata[8], 1);
        finish_edge();
        chk(count == 7, "R2 load over wrap", count, 7);
        // R2: mid-packet reprogram to 1, next write tagged
        step(1, 1, 0, 0, 0); finish_edge();
        step(0, 0, 1, 9, 0);
        chk(fifo_wdata[8] == 1, "R2 R4 reprog tag", fifo_wdata[8], 1);
        finish_edge();
        chk(count == 0, "R5 stop", count, 0);
        step(0, 0, 1, 9, 0);
        chk(fifo_wdata[8] == 0, "R5 no retag", fifo_wdata[8], 0);
        finish_edge();
        // R8: full at count 1 holds tag for the later accepted write
        step(1, 1, 0, 0, 0); finish_edge();
        step(0, 0, 1, 3, 1);
        chk(fifo_wdata[8] == 0, "R8 no tag full", fifo_wdata[8], 0);
        finish_edge();
        chk(count == 1, "R8 count hold", count, 1);
        step(0, 0, 1, 3, 0);
        chk(fifo_wdata[8] == 1, "R8 tag after stall", fifo_wdata[8], 1);
        finish_edge();

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule